// File: doc/BRIEF.md
# Two-Core Snooping Coherence Controller

This block keeps two small direct-mapped data caches coherent. Each core has its own cache and controller. The two controllers share one snooping bus in front of a simple memory model. A core issues one load or store at a time. Its controller tracks a four-state coherence code for each line: Invalid, Shared, Exclusive and Modified. The controller changes that state in two cases: when the local core makes a request, and when it watches a transaction that the other core drives on the shared bus.

A request that cannot finish locally raises a bus request. A fixed-priority arbiter grants the bus to one controller at a time. A granted transaction completes in its grant cycle. The four transaction types are:
- a read,
- a read-for-ownership,
- an invalidate,
- a write-back of a dirty victim line.

In that same cycle the peer's snoop logic reports two things: whether it holds the line, and whether it is sourcing dirty data. Dirty data sourced this way goes to the requester and to memory at the same time.

The cache line is four 32-bit words, and each cache holds eight lines. Word addresses are eight bits wide and split into three parts: bits [1:0] select the word, bits [4:2] the index, and bits [7:5] the tag.

Top module: `coh_dual_cache`

## Requirements
- R1: `resp_state` reports the final line state with each completion. The encoding is Invalid 2'b00, Shared 2'b01, Exclusive 2'b10, Modified 2'b11. A completion never reports Invalid.
- R2: Memory starts with the word at address a equal to 0xA5000000 | a. A load miss whose line no other cache holds performs exactly one read transaction (`bus_cmd` 0) and returns the memory word. The line ends Exclusive.
- R3: A load miss to a line that the peer holds Exclusive ends Shared. The peer's copy also becomes Shared, so the peer's next load of that line completes as Shared with no bus transaction.
- R4: A load that hits in Modified, Exclusive or Shared returns the cached word with no bus transaction, and the state is unchanged.
- R5: A store to a line in Modified or Exclusive completes with no bus transaction and leaves the line Modified.
- R6: A store to a Shared line drives one invalidate transaction (`bus_cmd` 2) and then ends Modified. The peer's copy becomes Invalid, so the peer's next load of that line needs a read.
- R7: When the peer snoops a read of a line it holds Modified, it sources the dirty line to the requester and writes it to memory, and both copies end Shared.
- R8: A store miss drives one read-for-ownership (`bus_cmd` 1) and ends Modified. The peer's copy becomes Invalid, and if that copy was Modified its data is merged under the new word.
- R9: When both controllers request the bus in the same cycle, core 0 is granted first (`bus_master` 0) and core 1 follows. At most one core is granted per cycle.
- R10: A miss whose victim line is Modified first drives a write-back (`bus_cmd` 3) and then the fill. The written-back data is later readable from memory by the other core.
- R11: After reset every line is Invalid, both `req_ready` bits are high, and the bus and the responses are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Per-core request strobe, taken while `req_ready` is high |
| req_ready | output | 2 | Per-core controller is idle and can take a request |
| req_write | input | 2 | Per-core request is a store (1) or load (0) |
| req_addr | input | 2x8 | Per-core word address |
| req_wdata | input | 2x32 | Per-core store data |
| resp_done | output | 2 | Per-core one-cycle completion pulse |
| resp_rdata | output | 2x32 | Loaded word, or the stored word for a store |
| resp_state | output | 2x2 | Line state after the request |
| bus_valid | output | 1 | A bus transaction is granted this cycle |
| bus_master | output | 1 | Index of the granted core |
| bus_cmd | output | 2 | Transaction type: 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_laddr | output | 6 | Line address of the transaction |

## Verification
The bench uses the default geometry: eight lines of four words, and an 8-bit word address. With so few lines, addresses one tag apart collide on the same index. This makes dirty-victim write-backs and the set-conflict retry easy to reach with a few directed requests. The three-bit tag gives enough distinct lines for these cases:
- every transition between the four states, reached from both the local side and the snoop side;
- lines shared between the cores;
- simultaneous bus requests, without the two cores touching each other's sets.

// File: rtl/coh_pkg.sv
package coh_pkg;

    parameter int DATA_W     = 32;
    parameter int LINE_WORDS = 4;
    parameter int NUM_LINES  = 8;
    parameter int ADDR_W     = 8;
    parameter int NUM_CORES  = 2;

    localparam int OFF_W     = $clog2(LINE_WORDS);
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W   = ADDR_W - OFF_W;
    localparam int MEM_LINES = 1 << LADDR_W;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } cstate_e;

    typedef enum logic [1:0] {
        BUS_RD  = 2'd0,
        BUS_RFO = 2'd1,
        BUS_INV = 2'd2,
        BUS_WB  = 2'd3
    } bcmd_e;

    typedef logic [LINE_WORDS-1:0][DATA_W-1:0] line_t;

    function automatic logic holds_valid(cstate_e s);
        return s != ST_I;
    endfunction

    function automatic logic writes_locally(cstate_e s);
        return (s == ST_M) || (s == ST_E);
    endfunction

    function automatic logic [DATA_W-1:0] mem_seed(logic [ADDR_W-1:0] a);
        return DATA_W'(32'hA500_0000) | DATA_W'(a);
    endfunction

endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter
    import coh_pkg::*;
#(
    parameter int N = NUM_CORES
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            gnt[i] = req[i] & ~taken;
            taken  = taken | req[i];
        end
    end

endmodule

// File: rtl/coh_memory.sv
module coh_memory
    import coh_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LADDR_W-1:0] rd_laddr,
    output line_t              rd_line,
    input  logic               wr_en,
    input  logic [LADDR_W-1:0] wr_laddr,
    input  line_t              wr_line
);

    line_t mem_q [MEM_LINES];

    assign rd_line = mem_q[rd_laddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < MEM_LINES; l++) begin
                for (int w = 0; w < LINE_WORDS; w++) begin
                    mem_q[l][w] <= mem_seed(ADDR_W'(l * LINE_WORDS + w));
                end
            end
        end else if (wr_en) begin
            mem_q[wr_laddr] <= wr_line;
        end
    end

endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
    import coh_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    // local core side
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               resp_done,
    output logic [DATA_W-1:0]  resp_rdata,
    output logic [1:0]         resp_state,
    // own bus transaction
    output logic               bus_req,
    input  logic               bus_gnt,
    output bcmd_e              bus_cmd,
    output logic [LADDR_W-1:0] bus_laddr,
    output line_t              bus_data,
    input  logic               fill_shared,
    input  line_t              fill_line,
    // snoop of the peer's granted transaction
    input  logic               snp_valid,
    input  bcmd_e              snp_cmd,
    input  logic [LADDR_W-1:0] snp_laddr,
    output logic               snp_hit,
    output logic               snp_shared,
    output logic               snp_supply,
    output line_t              snp_data
);

    typedef enum logic [1:0] {F_IDLE, F_LOOK, F_BUS} fsm_e;

    fsm_e               fsm_q;
    logic               op_write_q;
    logic [ADDR_W-1:0]  op_addr_q;
    logic [DATA_W-1:0]  op_wdata_q;
    bcmd_e              pend_q;

    cstate_e            st_q  [NUM_LINES];
    logic [TAG_W-1:0]   tag_q [NUM_LINES];
    line_t              dat_q [NUM_LINES];

    logic [OFF_W-1:0]   op_off;
    logic [IDX_W-1:0]   op_idx;
    logic [TAG_W-1:0]   op_tag;
    cstate_e            cur_st;
    logic               line_hit;
    logic [IDX_W-1:0]   s_idx;
    logic [TAG_W-1:0]   s_tag;
    logic               set_busy;

    assign op_off   = op_addr_q[OFF_W-1:0];
    assign op_idx   = op_addr_q[OFF_W +: IDX_W];
    assign op_tag   = op_addr_q[ADDR_W-1 -: TAG_W];
    assign cur_st   = st_q[op_idx];
    assign line_hit = holds_valid(cur_st) && (tag_q[op_idx] == op_tag);

    assign s_idx    = snp_laddr[IDX_W-1:0];
    assign s_tag    = snp_laddr[LADDR_W-1 -: TAG_W];
    // a peer transaction touching the set under work forces a re-decision
    assign set_busy = snp_valid && (s_idx == op_idx) && (fsm_q != F_IDLE);

    // snoop response, valid in the peer's grant cycle
    always_comb begin
        snp_hit    = snp_valid && holds_valid(st_q[s_idx]) && (tag_q[s_idx] == s_tag);
        snp_shared = snp_hit && (snp_cmd == BUS_RD);
        snp_supply = snp_hit && (st_q[s_idx] == ST_M) &&
                     ((snp_cmd == BUS_RD) || (snp_cmd == BUS_RFO));
        snp_data   = dat_q[s_idx];
    end

    // own bus request
    assign req_ready = (fsm_q == F_IDLE);
    assign bus_req   = (fsm_q == F_BUS);
    assign bus_cmd   = pend_q;
    assign bus_laddr = (pend_q == BUS_WB) ? {tag_q[op_idx], op_idx} : {op_tag, op_idx};
    assign bus_data  = dat_q[op_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q      <= F_IDLE;
            op_write_q <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
            pend_q     <= BUS_RD;
            resp_done  <= 1'b0;
            resp_rdata <= '0;
            resp_state <= ST_I;
            for (int l = 0; l < NUM_LINES; l++) begin
                st_q[l]  <= ST_I;
                tag_q[l] <= '0;
                dat_q[l] <= '0;
            end
        end else begin
            resp_done <= 1'b0;

            if (snp_hit) begin
                if (snp_cmd == BUS_RD) begin
                    st_q[s_idx] <= ST_S;
                end else if ((snp_cmd == BUS_RFO) || (snp_cmd == BUS_INV)) begin
                    st_q[s_idx] <= ST_I;
                end
            end

            unique case (fsm_q)
                F_IDLE: begin
                    if (req_valid) begin
                        op_write_q <= req_write;
                        op_addr_q  <= req_addr;
                        op_wdata_q <= req_wdata;
                        fsm_q      <= F_LOOK;
                    end
                end
                F_LOOK: begin
                    if (!set_busy) begin
                        if (line_hit && !op_write_q) begin
                            resp_done  <= 1'b1;
                            resp_rdata <= dat_q[op_idx][op_off];
                            resp_state <= cur_st;
                            fsm_q      <= F_IDLE;
                        end else if (line_hit && writes_locally(cur_st)) begin
                            dat_q[op_idx][op_off] <= op_wdata_q;
                            st_q[op_idx]          <= ST_M;
                            resp_done             <= 1'b1;
                            resp_rdata            <= op_wdata_q;
                            resp_state            <= ST_M;
                            fsm_q                 <= F_IDLE;
                        end else if (line_hit) begin
                            pend_q <= BUS_INV;
                            fsm_q  <= F_BUS;
                        end else if (cur_st == ST_M) begin
                            pend_q <= BUS_WB;
                            fsm_q  <= F_BUS;
                        end else begin
                            pend_q <= op_write_q ? BUS_RFO : BUS_RD;
                            fsm_q  <= F_BUS;
                        end
                    end
                end
                F_BUS: begin
                    if (bus_gnt) begin
                        unique case (pend_q)
                            BUS_RD: begin
                                dat_q[op_idx] <= fill_line;
                                tag_q[op_idx] <= op_tag;
                                st_q[op_idx]  <= fill_shared ? ST_S : ST_E;
                            end
                            BUS_RFO: begin
                                dat_q[op_idx] <= fill_line;
                                tag_q[op_idx] <= op_tag;
                                st_q[op_idx]  <= ST_M;
                            end
                            BUS_INV: st_q[op_idx] <= ST_M;
                            BUS_WB:  st_q[op_idx] <= ST_I;
                        endcase
                        fsm_q <= F_LOOK;
                    end else if (set_busy) begin
                        fsm_q <= F_LOOK;
                    end
                end
                default: fsm_q <= F_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/coh_dual_cache.sv
module coh_dual_cache
    import coh_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CORES-1:0]          req_valid,
    output logic [NUM_CORES-1:0]          req_ready,
    input  logic [NUM_CORES-1:0]          req_write,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0] req_addr,
    input  logic [NUM_CORES-1:0][DATA_W-1:0] req_wdata,
    output logic [NUM_CORES-1:0]          resp_done,
    output logic [NUM_CORES-1:0][DATA_W-1:0] resp_rdata,
    output logic [NUM_CORES-1:0][1:0]     resp_state,
    output logic                          bus_valid,
    output logic                          bus_master,
    output logic [1:0]                    bus_cmd,
    output logic [LADDR_W-1:0]            bus_laddr
);

    logic [NUM_CORES-1:0] core_breq;
    logic [NUM_CORES-1:0] core_gnt;
    logic [NUM_CORES-1:0] c_hit;
    logic [NUM_CORES-1:0] c_shared;
    logic [NUM_CORES-1:0] c_supply;
    bcmd_e                c_cmd   [NUM_CORES];
    logic [LADDR_W-1:0]   c_laddr [NUM_CORES];
    line_t                c_data  [NUM_CORES];
    line_t                c_sdata [NUM_CORES];

    line_t mem_rd_line;
    logic  mem_we;
    line_t mem_wd;
    logic  peer_hit;
    logic  peer_supply;
    bcmd_e cur_cmd;

    coh_arbiter #(.N(NUM_CORES)) u_arb (
        .req (core_breq),
        .gnt (core_gnt)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        localparam int P = NUM_CORES - 1 - c;
        line_t fill_line;

        assign fill_line = c_supply[P] ? c_sdata[P] : mem_rd_line;

        coh_cache_ctrl u_ctrl (
            .clk         (clk),
            .rst         (rst),
            .req_valid   (req_valid[c]),
            .req_ready   (req_ready[c]),
            .req_write   (req_write[c]),
            .req_addr    (req_addr[c]),
            .req_wdata   (req_wdata[c]),
            .resp_done   (resp_done[c]),
            .resp_rdata  (resp_rdata[c]),
            .resp_state  (resp_state[c]),
            .bus_req     (core_breq[c]),
            .bus_gnt     (core_gnt[c]),
            .bus_cmd     (c_cmd[c]),
            .bus_laddr   (c_laddr[c]),
            .bus_data    (c_data[c]),
            .fill_shared (c_shared[P]),
            .fill_line   (fill_line),
            .snp_valid   (core_gnt[P]),
            .snp_cmd     (c_cmd[P]),
            .snp_laddr   (c_laddr[P]),
            .snp_hit     (c_hit[c]),
            .snp_shared  (c_shared[c]),
            .snp_supply  (c_supply[c]),
            .snp_data    (c_sdata[c])
        );
    end

    // shared bus view of the granted transaction
    assign bus_valid   = |core_gnt;
    assign bus_master  = core_gnt[1];
    assign cur_cmd     = c_cmd[bus_master];
    assign bus_cmd     = cur_cmd;
    assign bus_laddr   = c_laddr[bus_master];
    assign peer_hit    = c_hit[~bus_master];
    assign peer_supply = c_supply[~bus_master];

    assign mem_we = bus_valid && ((cur_cmd == BUS_WB) || peer_supply);
    assign mem_wd = (cur_cmd == BUS_WB) ? c_data[bus_master] : c_sdata[~bus_master];

    coh_memory u_mem (
        .clk      (clk),
        .rst      (rst),
        .rd_laddr (bus_laddr),
        .rd_line  (mem_rd_line),
        .wr_en    (mem_we),
        .wr_laddr (bus_laddr),
        .wr_line  (mem_wd)
    );

endmodule

// File: rtl/coh_dual_cache_chk.sv
module coh_dual_cache_chk
    import coh_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CORES-1:0]     core_breq,
    input logic [NUM_CORES-1:0]     core_gnt,
    input logic                     bus_valid,
    input logic [1:0]               bus_cmd,
    input logic                     peer_hit,
    input logic                     peer_supply,
    input logic [NUM_CORES-1:0]     req_valid,
    input logic [NUM_CORES-1:0]     req_ready,
    input logic [NUM_CORES-1:0]     req_write,
    input logic [NUM_CORES-1:0]     resp_done,
    input logic [NUM_CORES-1:0][1:0] resp_state
);

    logic [NUM_CORES-1:0] wr_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend_q <= '0;
        end else begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (req_valid[c] && req_ready[c]) wr_pend_q[c] <= req_write[c];
            end
        end
    end

    // R9: one grant at most, only to a requester, core 0 first
    a_r9_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_gnt) && ((core_gnt & ~core_breq) == '0));
    a_r9_core0_first: assert property (@(posedge clk) disable iff (rst)
        core_breq[0] |-> core_gnt[0]);

    // R6: an invalidate is only issued from Shared, so the peer never sources dirty data
    a_r6_inv_no_dirty_peer: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_cmd == 2'd2) |-> !peer_supply);

    // R10: a dirty victim has no copy in the peer
    a_r10_wb_peer_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_cmd == 2'd3) |-> !peer_hit);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_resp
        // R5 and R8: every store completes Modified
        a_r5_store_modified: assert property (@(posedge clk) disable iff (rst)
            (resp_done[c] && wr_pend_q[c]) |-> (resp_state[c] == 2'b11));
        // R1: a completion never reports Invalid
        a_r1_done_valid: assert property (@(posedge clk) disable iff (rst)
            resp_done[c] |-> (resp_state[c] != 2'b00));
    end

endmodule

bind coh_dual_cache coh_dual_cache_chk u_chk (.*);

// File: tb/coh_dual_cache_test.sv
module coh_dual_cache_test;
    import coh_pkg::*;

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic [NUM_CORES-1:0]          req_valid = '0;
    logic [NUM_CORES-1:0]          req_ready;
    logic [NUM_CORES-1:0]          req_write = '0;
    logic [NUM_CORES-1:0][ADDR_W-1:0] req_addr = '0;
    logic [NUM_CORES-1:0][DATA_W-1:0] req_wdata = '0;
    logic [NUM_CORES-1:0]          resp_done;
    logic [NUM_CORES-1:0][DATA_W-1:0] resp_rdata;
    logic [NUM_CORES-1:0][1:0]     resp_state;
    logic                          bus_valid;
    logic                          bus_master;
    logic [1:0]                    bus_cmd;
    logic [LADDR_W-1:0]            bus_laddr;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    coh_dual_cache uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request; counts bus cycles granted to this core and the commands seen
    task automatic do_op(input int c, input bit w, input logic [7:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic [1:0] st,
                         output int nbus, output logic [3:0] cmds);
        @(negedge clk);
        while (!req_ready[c]) @(negedge clk);
        req_valid[c] = 1'b1; req_write[c] = w; req_addr[c] = a; req_wdata[c] = d;
        @(negedge clk);
        req_valid[c] = 1'b0;
        nbus = 0; cmds = '0;
        while (!resp_done[c]) begin
            if (bus_valid && bus_master == 1'(c)) begin
                nbus++;
                cmds[bus_cmd] = 1'b1;
            end
            @(negedge clk);
        end
        rd = resp_rdata[c];
        st = resp_state[c];
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R11 ready", 32'(req_ready), 32'h3);
        check("R11 bus idle", 32'(bus_valid), 32'h0);
        check("R11 no resp", 32'(resp_done), 32'h0);
    endtask

    task automatic t_excl_and_hits;
        logic [31:0] rd; logic [1:0] st; int nb; logic [3:0] cm;
        do_op(0, 0, 8'h08, 0, rd, st, nb, cm);
        check("R2 data", rd, 32'hA500_0008);
        check("R2 state E", 32'(st), 32'h2);
        check("R2 one read", 32'(nb), 32'h1);
        check("R2 cmd read", 32'(cm), 32'h1);
        do_op(0, 0, 8'h09, 0, rd, st, nb, cm);
        check("R4 hit E data", rd, 32'hA500_0009);
        check("R4 hit E no bus", 32'(nb), 32'h0);
        do_op(0, 1, 8'h09, 32'h1111_1111, rd, st, nb, cm);
        check("R5 store E no bus", 32'(nb), 32'h0);
        check("R5 state M", 32'(st), 32'h3);
        do_op(0, 0, 8'h09, 0, rd, st, nb, cm);
        check("R4 hit M data", rd, 32'h1111_1111);
        check("R4 hit M state", 32'(st), 32'h3);
        check("R4 hit M no bus", 32'(nb), 32'h0);
    endtask

    task automatic t_dirty_snoop;
        logic [31:0] rd; logic [1:0] st; int nb; logic [3:0] cm;
        do_op(1, 0, 8'h09, 0, rd, st, nb, cm);
        check("R7 sourced data", rd, 32'h1111_1111);
        check("R7 requester S", 32'(st), 32'h1);
        do_op(0, 0, 8'h09, 0, rd, st, nb, cm);
        check("R7 owner now S", 32'(st), 32'h1);
        check("R4 hit S no bus", 32'(nb), 32'h0);
        // push both copies out with clean reads, then reload from memory
        do_op(0, 0, 8'h29, 0, rd, st, nb, cm);
        check("R2 clean victim no wb", 32'(cm), 32'h1);
        do_op(1, 0, 8'h29, 0, rd, st, nb, cm);
        check("R3 second reader S", 32'(st), 32'h1);
        do_op(0, 0, 8'h09, 0, rd, st, nb, cm);
        check("R7 memory updated", rd, 32'h1111_1111);
        check("R2 reload E", 32'(st), 32'h2);
    endtask

    task automatic t_share_and_invalidate;
        logic [31:0] rd; logic [1:0] st; int nb; logic [3:0] cm;
        do_op(1, 0, 8'h40, 0, rd, st, nb, cm);
        check("R2 core1 E", 32'(st), 32'h2);
        do_op(0, 0, 8'h41, 0, rd, st, nb, cm);
        check("R3 requester S", 32'(st), 32'h1);
        check("R3 data", rd, 32'hA500_0041);
        do_op(1, 0, 8'h42, 0, rd, st, nb, cm);
        check("R3 peer S", 32'(st), 32'h1);
        check("R3 peer no bus", 32'(nb), 32'h0);
        do_op(0, 1, 8'h40, 32'h2222_2222, rd, st, nb, cm);
        check("R6 one bus op", 32'(nb), 32'h1);
        check("R6 cmd inv", 32'(cm), 32'h4);
        check("R6 state M", 32'(st), 32'h3);
        do_op(1, 0, 8'h40, 0, rd, st, nb, cm);
        check("R6 peer must read", 32'(cm), 32'h1);
        check("R7 new data", rd, 32'h2222_2222);
        check("R7 S", 32'(st), 32'h1);
    endtask

    task automatic t_ownership;
        logic [31:0] rd; logic [1:0] st; int nb; logic [3:0] cm;
        do_op(0, 1, 8'h64, 32'h3333_3333, rd, st, nb, cm);
        check("R8 cmd rfo", 32'(cm), 32'h2);
        check("R8 state M", 32'(st), 32'h3);
        do_op(1, 1, 8'h65, 32'h4444_4444, rd, st, nb, cm);
        check("R8 rfo from M", 32'(cm), 32'h2);
        do_op(0, 0, 8'h64, 0, rd, st, nb, cm);
        check("R8 old copy invalid", 32'(nb), 32'h1);
        check("R8 merged word", rd, 32'h3333_3333);
        check("R8 reader S", 32'(st), 32'h1);
        do_op(1, 0, 8'h65, 0, rd, st, nb, cm);
        check("R8 own word", rd, 32'h4444_4444);
        check("R7 owner S", 32'(st), 32'h1);
    endtask

    task automatic t_victim;
        logic [31:0] rd; logic [1:0] st; int nb; logic [3:0] cm;
        do_op(1, 1, 8'h10, 32'h5555_5555, rd, st, nb, cm);
        check("R8 rfo miss", 32'(cm), 32'h2);
        do_op(1, 0, 8'h30, 0, rd, st, nb, cm);
        check("R10 two bus ops", 32'(nb), 32'h2);
        check("R10 wb and read", 32'(cm), 32'h9);
        check("R10 fill data", rd, 32'hA500_0030);
        do_op(0, 0, 8'h10, 0, rd, st, nb, cm);
        check("R10 written back", rd, 32'h5555_5555);
        check("R10 reader E", 32'(st), 32'h2);
    endtask

    task automatic t_priority;
        int seen; logic [1:0] first_m; logic [1:0] got;
        logic [31:0] rd0; logic [31:0] rd1;
        @(negedge clk);
        while (req_ready != 2'b11) @(negedge clk);
        req_valid = 2'b11; req_write = 2'b00;
        req_addr[0] = 8'hC0; req_addr[1] = 8'hE8;
        @(negedge clk);
        req_valid = 2'b00;
        seen = 0; first_m = '0; got = '0; rd0 = '0; rd1 = '0;
        while (got != 2'b11) begin
            if (bus_valid) begin
                if (seen < 2) first_m[seen] = bus_master;
                seen++;
            end
            if (resp_done[0]) begin got[0] = 1'b1; rd0 = resp_rdata[0]; end
            if (resp_done[1]) begin got[1] = 1'b1; rd1 = resp_rdata[1]; end
            @(negedge clk);
        end
        check("R9 bus cycles", 32'(seen), 32'h2);
        check("R9 core0 then core1", 32'(first_m), 32'h2);
        check("R9 core0 data", rd0, 32'hA500_00C0);
        check("R9 core1 data", rd1, 32'hA500_00E8);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_excl_and_hits();
        t_dirty_snoop();
        t_share_and_invalidate();
        t_ownership();
        t_victim();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule